// File: doc/BRIEF.md
# Grouped Mutually-Exclusive Bus Selector

This block drives a registered data bus from one of several sources. Each source has its own enable line. The sources are split into groups at compile time. Inside a group, the enables are promised to be zero-hot or one-hot, so the group's candidate value is a flat AND-OR reduction: each source's data is masked by its enable, and all the masked words are ORed. No priority chain and no index decode are involved. Between groups there is a fixed priority. The lowest-numbered group that has any active enable supplies the next bus value. When no enable is active, the bus keeps its value.

Because the in-group promise cannot be enforced by construction, the block watches it every cycle. If two enables of the same group are active together, a one-cycle violation pulse follows on the next clock and a sticky flag latches until reset. The bus result on such a cycle is still well defined: it is the OR of every active source in the winning group.

A typical use is a wide result or return bus fed by several units whose grants come from arbiters that are already one-hot. Each arbiter domain becomes one group, and the domains are ranked against each other.

Top module: `grp_andor_sel`

## Requirements
- R1: An active-high reset, applied without waiting for a clock, drives `bus_q`, `viol_pulse` and `viol_sticky` to zero.
- R2: When exactly one enable is active, `bus_q` equals that source's data word after the next rising clock edge. Source s occupies `src_data[s*DATA_W +: DATA_W]`.
- R3: Group priority follows the group index, and index 0 is the highest. A group supplies the bus only when every enable in all lower-indexed groups is inactive. The group of source s is field s, `GIDX_W` bits wide, of `SRC_GRP`. The default places sources 0 to 2 in group 0 and sources 3 to 5 in group 1.
- R4: On a clock edge where no enable is active, `bus_q` keeps its previous value.
- R5: `viol_pulse` is high for exactly the one cycle after each rising edge at which some group had two or more active enables. It is low otherwise.
- R6: `viol_sticky` goes high together with the first `viol_pulse` and stays high until reset.
- R7: When the winning group has several active enables, the next `bus_q` is the bitwise OR of the data of all its active sources.
- R8: A multiple-hot condition in a lower-priority group is still reported through `viol_pulse`, even while a higher-priority group supplies the bus.
- R9: One active enable in each of two different groups is not a violation. The higher-priority group's source supplies the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| src_en | input | NUM_SRC | Per-source enable, bit s for source s |
| src_data | input | NUM_SRC*DATA_W | Concatenated source data, source 0 in the low bits |
| bus_q | output | DATA_W | Registered selected bus value |
| viol_pulse | output | 1 | One-cycle flag for a same-group multiple-hot edge |
| viol_sticky | output | 1 | Latched violation flag, cleared only by reset |

## Verification
The bench goes after several corner cases:
- **Enables in two groups at once.** A selector that lets a later group win, or ORs across groups, would put the wrong word or a blended word on the bus.
- **Two enables in one group.** A design that hid a priority mux inside the group would pick one word instead of the OR of both.
- **A violation only in the losing group.** A checker that looked only at the winning group would stay silent.
- **Idle cycles after a load.** These catch a register that clears instead of holding.
- **Quiet cycles after a violation, and a reset during a run.** Clean cycles after the violation catch a sticky flag that decays, or a pulse that stretches beyond one cycle. A reset asserted in the middle of a run catches a reset that waits for the clock.
- **Randomized enable patterns.** These mix every case, and a reference model predicts each edge.

// File: rtl/gsel_pkg.sv
`timescale 1ns/1ps
// Shared types for the grouped AND-OR selector.
package gsel_pkg;

   // Per-group reduction status, carried from the group reducers to the picker.
   typedef struct packed {
      logic hit;    // at least one member enable active
      logic multi;  // two or more member enables active
   } grp_stat_t;

endpackage

// File: rtl/gsel_group_reduce.sv
`timescale 1ns/1ps
// One group: masked-data OR over member sources plus a same-group
// multiple-hot detector. No ordering between members.
module gsel_group_reduce #(
   parameter int unsigned          DATA_W      = 64,
   parameter int unsigned          NUM_SRC     = 6,
   parameter logic [NUM_SRC-1:0]   MEMBER_MASK = '1
) (
   input  logic [NUM_SRC-1:0]        src_en,
   input  logic [NUM_SRC*DATA_W-1:0] src_data,
   output gsel_pkg::grp_stat_t       stat,
   output logic [DATA_W-1:0]         value
);

   localparam int unsigned MEMBER_CNT = $countones(MEMBER_MASK);

   logic [NUM_SRC-1:0] live_en;
   assign live_en = src_en & MEMBER_MASK;

   // Masked data words of members, zero for non-members.
   logic [DATA_W-1:0] masked [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_mask
      if (MEMBER_MASK[s]) begin : g_member
         assign masked[s] = src_data[s*DATA_W +: DATA_W] & {DATA_W{src_en[s]}};
      end else begin : g_other
         assign masked[s] = '0;
      end
   end

   // Flat OR of all masked words (sum of products).
   always_comb begin
      value = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         value = value | masked[s];
      end
   end

   assign stat.hit = |live_en;

   // Multiple-hot detection: a single-member group can never be multi-hot.
   if (MEMBER_CNT < 2) begin : g_single
      assign stat.multi = 1'b0;
   end else begin : g_multi
      logic seen, dbl;
      always_comb begin
         seen = 1'b0;
         dbl  = 1'b0;
         for (int s = 0; s < NUM_SRC; s++) begin
            dbl  = dbl  | (seen & live_en[s]);
            seen = seen | live_en[s];
         end
      end
      assign stat.multi = dbl;
   end

endmodule

// File: rtl/gsel_prio_pick.sv
`timescale 1ns/1ps
// Strict priority between groups: lowest group index with a hit wins.
module gsel_prio_pick #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned NUM_GRP = 2
) (
   input  gsel_pkg::grp_stat_t        stat  [NUM_GRP],
   input  logic [NUM_GRP*DATA_W-1:0]  value,
   output logic                       load,
   output logic [DATA_W-1:0]          next_val
);

   always_comb begin
      load     = 1'b0;
      next_val = '0;
      for (int g = NUM_GRP - 1; g >= 0; g--) begin
         if (stat[g].hit) begin
            load     = 1'b1;
            next_val = value[g*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/gsel_viol_track.sv
`timescale 1ns/1ps
// Registers the per-group multiple-hot flags into a pulse and a sticky flag.
module gsel_viol_track #(
   parameter int unsigned NUM_GRP = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_GRP-1:0] grp_multi,
   output logic               viol_pulse,
   output logic               viol_sticky
);

   logic any_multi;
   assign any_multi = |grp_multi;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         viol_pulse  <= 1'b0;
         viol_sticky <= 1'b0;
      end else begin
         viol_pulse  <= any_multi;
         viol_sticky <= viol_sticky | any_multi;
      end
   end

endmodule

// File: rtl/grp_andor_sel.sv
`timescale 1ns/1ps
// Grouped one-hot AND-OR bus selector, top level.
module grp_andor_sel #(
   parameter int unsigned                  DATA_W  = 64,
   parameter int unsigned                  NUM_SRC = 6,
   parameter int unsigned                  NUM_GRP = 2,
   parameter int unsigned                  GIDX_W  = 4,
   parameter logic [NUM_SRC*GIDX_W-1:0]    SRC_GRP = {4'd1, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0}
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_SRC-1:0]          src_en,
   input  logic [NUM_SRC*DATA_W-1:0]   src_data,
   output logic [DATA_W-1:0]           bus_q,
   output logic                        viol_pulse,
   output logic                        viol_sticky
);

   localparam int unsigned VAL_W = NUM_GRP * DATA_W;

   function automatic int unsigned grp_at(input int unsigned s);
      return int'(SRC_GRP[s*GIDX_W +: GIDX_W]);
   endfunction

   function automatic logic [NUM_SRC-1:0] mask_of(input int unsigned g);
      logic [NUM_SRC-1:0] m;
      m = '0;
      for (int unsigned s = 0; s < NUM_SRC; s++) begin
         m[s] = (grp_at(s) == g);
      end
      return m;
   endfunction

   // ---------------- elaboration-time parameter checks ----------------
   if (DATA_W < 1 || NUM_SRC < 1 || NUM_GRP < 1) begin : g_bad_size
      $error("grp_andor_sel: DATA_W, NUM_SRC and NUM_GRP must be at least 1");
   end
   if (NUM_GRP > (1 << GIDX_W)) begin : g_bad_idx_w
      $error("grp_andor_sel: GIDX_W too narrow for NUM_GRP");
   end
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_map_chk
      if (grp_at(s) >= NUM_GRP) begin : g_range
         $error("grp_andor_sel: source group index out of range");
      end
      if (s > 0) begin : g_order
         if (grp_at(s) < grp_at(s - 1)) begin : g_desc
            $error("grp_andor_sel: sources must be numbered in ascending group order");
         end
      end
   end
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_fill_chk
      if (mask_of(g) == '0) begin : g_empty
         $error("grp_andor_sel: every group needs at least one source");
      end
   end

   // ---------------- per-group reduction ----------------
   gsel_pkg::grp_stat_t       stat [NUM_GRP];
   logic [VAL_W-1:0]          grp_val;
   logic [NUM_GRP-1:0]        grp_multi;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      gsel_group_reduce #(
         .DATA_W      (DATA_W),
         .NUM_SRC     (NUM_SRC),
         .MEMBER_MASK (mask_of(g))
      ) i_reduce (
         .src_en   (src_en),
         .src_data (src_data),
         .stat     (stat[g]),
         .value    (grp_val[g*DATA_W +: DATA_W])
      );
      assign grp_multi[g] = stat[g].multi;
   end

   // ---------------- group priority ----------------
   logic              load;
   logic [DATA_W-1:0] next_val;

   gsel_prio_pick #(
      .DATA_W  (DATA_W),
      .NUM_GRP (NUM_GRP)
   ) i_pick (
      .stat     (stat),
      .value    (grp_val),
      .load     (load),
      .next_val (next_val)
   );

   // ---------------- output register ----------------
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         bus_q <= '0;
      end else if (load) begin
         bus_q <= next_val;
      end
   end

   // ---------------- violation reporting ----------------
   gsel_viol_track #(
      .NUM_GRP (NUM_GRP)
   ) i_viol (
      .clk         (clk),
      .rst         (rst),
      .grp_multi   (grp_multi),
      .viol_pulse  (viol_pulse),
      .viol_sticky (viol_sticky)
   );

endmodule

// File: rtl/gsel_checker.sv
`timescale 1ns/1ps
// Property checker for grp_andor_sel, bound to every instance.
module gsel_checker #(
   parameter int unsigned                  DATA_W  = 64,
   parameter int unsigned                  NUM_SRC = 6,
   parameter int unsigned                  NUM_GRP = 2,
   parameter int unsigned                  GIDX_W  = 4,
   parameter logic [NUM_SRC*GIDX_W-1:0]    SRC_GRP = {4'd1, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0}
) (
   input logic                clk,
   input logic                rst,
   input logic [NUM_SRC-1:0]  src_en,
   input logic [DATA_W-1:0]   bus_q,
   input logic                viol_pulse,
   input logic                viol_sticky
);

   // Independent per-group multiple-hot view, built from the map by counting.
   logic [NUM_GRP-1:0] chk_multi;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_cnt
      logic [NUM_SRC-1:0] members;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
         assign members[s] = (SRC_GRP[s*GIDX_W +: GIDX_W] == GIDX_W'(g));
      end
      assign chk_multi[g] = $countones(src_en & members) > 1;
   end

   // R4: idle edge leaves the bus unchanged
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (src_en == '0) |=> $stable(bus_q));

   // R5: a multiple-hot edge is followed by the pulse
   p_pulse_on_multi_r5: assert property (@(posedge clk) disable iff (rst)
      (|chk_multi) |=> viol_pulse);

   // R5: the pulse only follows a multiple-hot edge
   p_pulse_only_multi_r5: assert property (@(posedge clk) disable iff (rst)
      viol_pulse |-> $past(|chk_multi));

   // R6: the sticky flag never drops outside reset
   p_sticky_keep_r6: assert property (@(posedge clk) disable iff (rst)
      viol_sticky |=> viol_sticky);

   // R6: the sticky flag rises together with a pulse
   p_sticky_rise_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(viol_sticky) |-> viol_pulse);

   // R6: a pulse always comes with the sticky flag set
   p_pulse_sets_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      viol_pulse |-> viol_sticky);

endmodule

bind grp_andor_sel gsel_checker #(
   .DATA_W  (DATA_W),
   .NUM_SRC (NUM_SRC),
   .NUM_GRP (NUM_GRP),
   .GIDX_W  (GIDX_W),
   .SRC_GRP (SRC_GRP)
) i_gsel_chk (
   .clk         (clk),
   .rst         (rst),
   .src_en      (src_en),
   .bus_q       (bus_q),
   .viol_pulse  (viol_pulse),
   .viol_sticky (viol_sticky)
);

// File: tb/test_grp_andor_sel.sv
`timescale 1ns/1ps
module test_grp_andor_sel;

   localparam int W = 64;
   localparam int N = 6;

   logic             clk = 1'b0;
   logic             rst;
   logic [N-1:0]     src_en;
   logic [N*W-1:0]   src_data;
   logic [W-1:0]     bus_q;
   logic             viol_pulse;
   logic             viol_sticky;

   always #5 clk = ~clk;

   grp_andor_sel i_grp_andor_sel (
      .clk         (clk),
      .rst         (rst),
      .src_en      (src_en),
      .src_data    (src_data),
      .bus_q       (bus_q),
      .viol_pulse  (viol_pulse),
      .viol_sticky (viol_sticky)
   );

   typedef struct {
      logic [W-1:0] bus;
      logic         pulse;
      logic         sticky;
      string        req;
   } exp_t;

   exp_t         sb_q[$];
   logic [W-1:0] m_bus;
   logic         m_sticky;
   int           n_chk = 0;
   int           n_fail = 0;

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Group map of the default configuration: sources 0..2 -> group 0, 3..5 -> group 1.
   function automatic int grp_of(input int s);
      return (s < 3) ? 0 : 1;
   endfunction

   // Driver: applies one enable pattern, predicts the edge result, queues it.
   task automatic step(input logic [N-1:0] e, input string req);
      logic [W-1:0] or_val [2];
      int           cnt [2];
      logic         multi;
      @(negedge clk);
      src_en = e;
      for (int g = 0; g < 2; g++) begin
         or_val[g] = '0;
         cnt[g]    = 0;
      end
      for (int s = 0; s < N; s++) begin
         if (e[s]) begin
            or_val[grp_of(s)] = or_val[grp_of(s)] | src_data[s*W +: W];
            cnt[grp_of(s)]++;
         end
      end
      multi = (cnt[0] > 1) || (cnt[1] > 1);
      if (cnt[0] > 0)      m_bus = or_val[0];
      else if (cnt[1] > 0) m_bus = or_val[1];
      m_sticky = m_sticky | multi;
      @(posedge clk);
      #1;
      sb_q.push_back('{m_bus, multi, m_sticky, req});
   endtask

   // Monitor: compares one queued prediction per falling edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         chk(it.req, "bus_q", bus_q, it.bus);
         chk(it.req, "viol_pulse", W'(viol_pulse), W'(it.pulse));
         chk(it.req, "viol_sticky", W'(viol_sticky), W'(it.sticky));
      end
   end

   task automatic drain();
      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic set_data(input int seed);
      for (int s = 0; s < N; s++) begin
         src_data[s*W +: W] = (W'(64'hA5 + seed + s) << (8*s)) | (W'(1) << (56 + s));
      end
   endtask

   initial begin
      rst = 1'b1;
      src_en = '0;
      set_data(0);
      m_bus = '0;
      m_sticky = 1'b0;
      #12;
      chk("R1", "bus_q at reset", bus_q, '0);
      chk("R1", "pulse at reset", W'(viol_pulse), '0);
      chk("R1", "sticky at reset", W'(viol_sticky), '0);
      @(negedge clk);
      rst = 1'b0;

      // R4: idle after reset keeps zero
      step('0, "R4");
      // R2: each source alone
      for (int s = 0; s < N; s++) step(N'(1) << s, "R2");
      // R4: idle holds the last loaded word
      step('0, "R4");
      step('0, "R4");
      // R3: group 0 beats group 1
      step(6'b100_000, "R3");
      step(6'b100_001, "R3");
      // R9: one per group is no violation
      step(6'b001_010, "R9");
      step(6'b010_100, "R9");
      // R7 / R5: two in group 0 -> OR and pulse
      step(6'b000_101, "R7");
      // R6: sticky stays after clean cycles, pulse drops
      step(6'b000_010, "R6");
      step('0, "R6");
      // R8: violation in losing group still reported
      step(6'b011_100, "R8");
      // R7: three-hot in group 1 with group 0 idle
      step(6'b111_000, "R7");
      step(6'b000_001, "R5");
      drain();

      // R1: asynchronous reset in the middle of a run
      @(negedge clk);
      #2;
      rst = 1'b1;
      #1;
      chk("R1", "bus_q async reset", bus_q, '0);
      chk("R1", "pulse async reset", W'(viol_pulse), '0);
      chk("R1", "sticky async reset", W'(viol_sticky), '0);
      m_bus = '0;
      m_sticky = 1'b0;
      @(negedge clk);
      rst = 1'b0;

      // R5 and R6 again from a clean state, then mixed random patterns for R3
      step(6'b010_000, "R5");
      set_data(7);
      for (int i = 0; i < 150; i++) begin
         step(N'($urandom), "R3");
      end
      drain();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule